// File: doc/BRIEF.md
# Two-Level Lookahead Adder/Subtractor

This block adds or subtracts two 16-bit two's-complement operands in a single combinational pass. Each bit forms a generate term (both operand bits set) and a propagate term (operand bits differ). The bits are grouped into 4-bit slices. Inside each slice, every carry is written out in flat sum-of-products form from the bit terms and the slice's incoming carry, so no carry waits on a neighbour's carry.

Each slice also reports a group generate and a group propagate to a second-level lookahead unit. That unit has the same structure as the one inside a slice. It forms the carry into every slice and the final carry-out directly from the group terms and the block's carry-in. Subtraction uses the same adder: the second operand is inverted and the carry-in is forced high. The outputs are the sum, the raw carry-out and a signed overflow flag.

The operation control is decoded into a two-value operation type: add or subtract. That decode is the only mode logic. The block holds no state and has no clock.

Top module: `lka_addsub`

## Requirements
- R1: With `sub_i` = 0, `sum_o` equals (`a_i` + `b_i` + `carry_i`) modulo 2^16.
- R2: `carry_o` equals bit 16 of the 17-bit unsigned total of the two adder inputs and the effective carry-in.
- R3: With `sub_i` = 1, `sum_o` equals `a_i` + (bitwise NOT `b_i`) + 1 modulo 2^16, which is `a_i` − `b_i`. `carry_o` is 1 exactly when `a_i` ≥ `b_i` as unsigned values.
- R4: With `sub_i` = 1, `carry_i` has no effect: `sum_o`, `carry_o` and `ovf_o` are identical for `carry_i` = 0 and `carry_i` = 1.
- R5: `ovf_o` is 1 exactly when the carry into bit 15 differs from the carry out of bit 15. Equivalently, the adder's two inputs (after the subtract inversion) have equal sign bits and `sum_o` bit 15 differs from them.
- R6: `carry_o` is reported raw and does not imply overflow. For example, 0xFFFF + 0x0001 gives `carry_o` = 1 and `ovf_o` = 0.
- R7: A carry that must cross all 16 positions resolves correctly. 0xFFFF + 0x0000 with `carry_i` = 1 gives `sum_o` = 0x0000 and `carry_o` = 1.
- R8: Carries cross each 4-bit slice boundary through the second-level unit. 0x000F + 1, 0x00FF + 1 and 0x0FFF + 1 give 0x0010, 0x0100 and 0x1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand (subtrahend when subtracting) |
| carry_i | input | 1 | Carry-in, used only when adding |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| sum_o | output | 16 | Sum or difference |
| carry_o | output | 1 | Raw carry out of bit 15 |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
On every input change, the assertions compare the sum and the carry-out against a wide behavioural addition. They also check the difference when subtracting, and check the overflow flag against the sign rule on the operands.

The assertions cannot show that `carry_i` is ignored under subtraction, because that needs the same operands applied twice. Only the bench's scenarios show it. The same holds for the specific carry chains that cross each slice boundary and the full 16-bit propagation case, which the bench drives on purpose.

// File: rtl/lka_pkg.sv
package lka_pkg;

    localparam int unsigned LKA_SLICE_W = 4;
    localparam int unsigned LKA_SLICES  = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } lka_op_e;

endpackage

// File: rtl/lka_carry_unit.sv
module lka_carry_unit #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] p_i,
    input  logic [N-1:0] g_i,
    input  logic         c_i,
    output logic [N-1:0] c_o,
    output logic         gp_o,
    output logic         gg_o
);

    // Flat two-level carry expansion: each carry is an OR of AND terms
    // built only from p_i, g_i and c_i.
    always_comb begin
        logic acc;
        logic term;
        c_o[0] = c_i;
        for (int k = 1; k < N; k++) begin
            term = c_i;
            for (int j = 0; j < k; j++) begin
                term = term & p_i[j];
            end
            acc = term;
            for (int j = 0; j < k; j++) begin
                term = g_i[j];
                for (int m = j + 1; m < k; m++) begin
                    term = term & p_i[m];
                end
                acc = acc | term;
            end
            c_o[k] = acc;
        end
    end

    // Group terms for the next level.
    always_comb begin
        logic acc;
        logic term;
        gp_o = &p_i;
        acc  = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = g_i[j];
            for (int m = j + 1; m < N; m++) begin
                term = term & p_i[m];
            end
            acc = acc | term;
        end
        gg_o = acc;
    end

endmodule

// File: rtl/lka_slice.sv
module lka_slice #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] sum_o,
    output logic         gp_o,
    output logic         gg_o,
    output logic         cmsb_o
);

    logic [W-1:0] bit_p;
    logic [W-1:0] bit_g;
    logic [W-1:0] bit_c;

    assign bit_p = a_i ^ b_i;
    assign bit_g = a_i & b_i;

    lka_carry_unit #(.N(W)) u_cu (
        .p_i  (bit_p),
        .g_i  (bit_g),
        .c_i  (c_i),
        .c_o  (bit_c),
        .gp_o (gp_o),
        .gg_o (gg_o)
    );

    assign sum_o  = bit_p ^ bit_c;
    assign cmsb_o = bit_c[W-1];

endmodule

// File: rtl/lka_addsub.sv
module lka_addsub
    import lka_pkg::*;
#(
    parameter int unsigned SLICE_W = LKA_SLICE_W,
    parameter int unsigned SLICES  = LKA_SLICES
) (
    input  logic [SLICE_W*SLICES-1:0] a_i,
    input  logic [SLICE_W*SLICES-1:0] b_i,
    input  logic                      carry_i,
    input  logic                      sub_i,
    output logic [SLICE_W*SLICES-1:0] sum_o,
    output logic                      carry_o,
    output logic                      ovf_o
);

    localparam int unsigned WIDTH = SLICE_W * SLICES;

    lka_op_e            op;
    logic [WIDTH-1:0]   b_eff;
    logic               c0;
    logic [SLICES-1:0]  grp_p;
    logic [SLICES-1:0]  grp_g;
    logic [SLICES-1:0]  grp_c;
    logic [SLICES-1:0]  grp_cmsb;
    logic               top_p;
    logic               top_g;

    assign op = lka_op_e'(sub_i);

    always_comb begin
        unique case (op)
            OP_ADD: begin
                b_eff = b_i;
                c0    = carry_i;
            end
            OP_SUB: begin
                b_eff = ~b_i;
                c0    = 1'b1;
            end
            default: begin
                b_eff = b_i;
                c0    = carry_i;
            end
        endcase
    end

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        lka_slice #(.W(SLICE_W)) u_slice (
            .a_i    (a_i[s*SLICE_W +: SLICE_W]),
            .b_i    (b_eff[s*SLICE_W +: SLICE_W]),
            .c_i    (grp_c[s]),
            .sum_o  (sum_o[s*SLICE_W +: SLICE_W]),
            .gp_o   (grp_p[s]),
            .gg_o   (grp_g[s]),
            .cmsb_o (grp_cmsb[s])
        );
    end

    lka_carry_unit #(.N(SLICES)) u_level2 (
        .p_i  (grp_p),
        .g_i  (grp_g),
        .c_i  (c0),
        .c_o  (grp_c),
        .gp_o (top_p),
        .gg_o (top_g)
    );

    assign carry_o = top_g | (top_p & c0);
    assign ovf_o   = grp_cmsb[SLICES-1] ^ carry_o;

endmodule

// File: rtl/lka_addsub_chk.sv
module lka_addsub_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             carry_i,
    input logic             sub_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o,
    input logic             ovf_o
);

    logic [WIDTH:0]   wide;
    logic [WIDTH-1:0] bx;
    logic [WIDTH-1:0] diff;
    logic             sgn_ovf;

    always_comb begin
        bx      = sub_i ? ~b_i : b_i;
        wide    = {1'b0, a_i} + {1'b0, bx} + {{WIDTH{1'b0}}, (sub_i | carry_i)};
        diff    = a_i - b_i;
        sgn_ovf = (a_i[WIDTH-1] == bx[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
    end

    always_comb begin
        AST_SUM_MATCH:  assert (sub_i || sum_o == wide[WIDTH-1:0]) else $error("sum mismatch"); // R1
        AST_CARRY_OUT:  assert (carry_o == wide[WIDTH]) else $error("carry mismatch");          // R2
        AST_SUB_DIFF:   assert (!sub_i || sum_o == diff) else $error("difference mismatch");    // R3
        AST_SUB_BORROW: assert (!sub_i || carry_o == (a_i >= b_i)) else $error("borrow wrong"); // R3
        AST_OVF_SIGN:   assert (ovf_o == sgn_ovf) else $error("overflow mismatch");             // R5
    end

endmodule

bind lka_addsub lka_addsub_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .sub_i   (sub_i),
    .sum_o   (sum_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o)
);

// File: tb/tb_lka_addsub.sv
module tb_lka_addsub;

    logic        clk = 1'b0;
    logic [15:0] a, b, sum;
    logic        cin, sub, cout, ovf;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    lka_addsub dut (
        .a_i(a), .b_i(b), .carry_i(cin), .sub_i(sub),
        .sum_o(sum), .carry_o(cout), .ovf_o(ovf)
    );

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%b sub=%b actual=%h expected=%h",
                     req, a, b, cin, sub, act, exp);
        end
    endtask

    // Applies one vector away from the clock edge and checks against a
    // reference computed here from the requirements.
    task automatic apply(input string req, input logic [15:0] ta, input logic [15:0] tb_,
                         input logic ci, input logic sb);
        logic [15:0] bx;
        logic [16:0] w;
        logic        o;
        @(negedge clk);
        a = ta; b = tb_; cin = ci; sub = sb;
        #1;
        bx = sb ? ~tb_ : tb_;
        w  = {1'b0, ta} + {1'b0, bx} + {16'd0, (sb | ci)};
        o  = (ta[15] == bx[15]) && (w[15] != ta[15]);
        check(req, {cout, ovf, sum}, {w[16], o, w[15:0]});
    endtask

    task automatic t_reset_state;
        apply("R1 idle zero", 16'h0000, 16'h0000, 1'b0, 1'b0);
        check("R1 idle sum", {2'b00, sum}, 18'h0);
    endtask

    task automatic t_add_basic;
        apply("R1", 16'h1234, 16'h4321, 1'b0, 1'b0);
        check("R1 direct", {2'b00, sum}, {2'b00, 16'h5555});
        apply("R1 cin", 16'h1234, 16'h4321, 1'b1, 1'b0);
        check("R1 cin direct", {2'b00, sum}, {2'b00, 16'h5556});
        apply("R2", 16'h8000, 16'h8000, 1'b0, 1'b0);
        check("R2 carry", {17'd0, cout}, 18'd1);
    endtask

    task automatic t_sub;
        apply("R3", 16'd100, 16'd58, 1'b0, 1'b1);
        check("R3 diff", {cout, 1'b0, sum}, {1'b1, 1'b0, 16'd42});
        apply("R3 borrow", 16'd5, 16'd9, 1'b0, 1'b1);
        check("R3 neg", {cout, 1'b0, sum}, {1'b0, 1'b0, 16'hFFFC});
    endtask

    task automatic t_sub_ignores_cin;
        logic [17:0] first;
        apply("R4 cin0", 16'h7A5C, 16'h1F03, 1'b0, 1'b1);
        first = {cout, ovf, sum};
        apply("R4 cin1", 16'h7A5C, 16'h1F03, 1'b1, 1'b1);
        check("R4 same", {cout, ovf, sum}, first);
    endtask

    task automatic t_overflow;
        apply("R5 pos", 16'h7FFF, 16'h0001, 1'b0, 1'b0);
        check("R5 pos flag", {17'd0, ovf}, 18'd1);
        apply("R5 neg", 16'h8000, 16'hFFFF, 1'b0, 1'b0);
        check("R5 neg flag", {17'd0, ovf}, 18'd1);
        apply("R5 sub", 16'h8000, 16'h0001, 1'b0, 1'b1);
        check("R5 sub flag", {17'd0, ovf}, 18'd1);
        apply("R5 none", 16'h3000, 16'h2000, 1'b0, 1'b0);
        check("R5 none flag", {17'd0, ovf}, 18'd0);
    endtask

    task automatic t_raw_carry;
        apply("R6", 16'hFFFF, 16'h0001, 1'b0, 1'b0);
        check("R6 raw", {cout, ovf, sum}, {1'b1, 1'b0, 16'h0000});
    endtask

    task automatic t_full_ripple;
        apply("R7", 16'hFFFF, 16'h0000, 1'b1, 1'b0);
        check("R7 chain", {cout, 1'b0, sum}, {1'b1, 1'b0, 16'h0000});
    endtask

    task automatic t_slice_edges;
        apply("R8 s1", 16'h000F, 16'h0001, 1'b0, 1'b0);
        check("R8 s1 v", {2'b00, sum}, {2'b00, 16'h0010});
        apply("R8 s2", 16'h00FF, 16'h0001, 1'b0, 1'b0);
        check("R8 s2 v", {2'b00, sum}, {2'b00, 16'h0100});
        apply("R8 s3", 16'h0FFF, 16'h0001, 1'b0, 1'b0);
        check("R8 s3 v", {2'b00, sum}, {2'b00, 16'h1000});
    endtask

    task automatic t_random;
        for (int i = 0; i < 2000; i++) begin
            apply("R1 R2 R3 R5 random", 16'($urandom), 16'($urandom),
                  1'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        a = 16'h0; b = 16'h0; cin = 1'b0; sub = 1'b0;
        t_reset_state();
        t_add_basic();
        t_sub();
        t_sub_ignores_cin();
        t_overflow();
        t_raw_carry();
        t_full_ripple();
        t_slice_edges();
        t_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule